// File: doc/BRIEF.md
# Stop Recovery and Clock Enable Controller

This block holds a small write-only control register and uses it to steer two things: how a sleeping core is woken from its STOP state, and how often the system and timer clock enables fire. Software picks one of seven wake pins or pin groups (or none), the level on that source that counts as a wake, whether the reset held after waking is short or long, and the divide ratio of the clock enables. Both enables come from a single free-running counter and stay low for as long as the block is in STOP.

While in STOP, the selected source is brought through a synchronizer and compared with the programmed level. A match produces a one-cycle wake pulse, leaves STOP, turns off the divide-by-16 prescaler, sets a sticky flag and starts a reset request that lasts a programmed number of oscillator cycles. Software can read only the flag. Only a power-on reset clears it. An external reset restores the other fields but leaves the flag alone.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After a power-on reset, stop_flag, rst_req, wake_pulse and rd_data are 0, and the register fields are all 0.
- R2: A read at address REG_ADDR (0x0B) returns stop_flag in bit 7 and zeros in bits 6:0. Any other address reads 0. Bit 7 of a write is ignored.
- R3: When stop_req is high while the block is not in STOP and rst_req is low, the block enters STOP at that clock edge. While it is in STOP, neither clock enable pulses.
- R4: Register bits 4:2 select the wake source as follows. 000 is none (only a reset leaves STOP). 001 to 100 are wake_pa[0] to wake_pa[3]. 101 is wake_pb[7]. 110 is the NOR of wake_pb[3:0]. 111 is the NOR of wake_pb[7:0].
- R5: Register bit 6 gives the wake level: 0 means a low source wakes, 1 means a high source wakes.
- R6: While in STOP, a source level that has passed SYNC_STAGES synchronizer flops and matches the wake level ends STOP at the next edge and raises wake_pulse for exactly one cycle.
- R7: stop_flag is set by a wake, survives ext_rst, and is cleared only by por.
- R8: rst_req goes high together with wake_pulse. It stays high for SHORT_DLY (64) cycles if register bit 5 was 1 at the wake, or LONG_DLY (4096) cycles if it was 0. A stop_req is ignored while rst_req is high.
- R9: Outside STOP, the clock enables pulse once every 2 cycles when register bit 1 is 0, and every cycle when it is 1.
- R10: Register bit 0 multiplies the enable period by 16. A wake clears bit 0, and that clear overrides a write in the same cycle. The other written fields still take effect.
- R11: ext_rst leaves STOP, cancels any reset request and restores all register fields to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| ext_rst | input | 1 | External reset, synchronous, active high |
| stop_req | input | 1 | Request from the core to enter STOP |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data (flag in bit 7) |
| wake_pa | input | 4 | Single-pin wake sources |
| wake_pb | input | 8 | Wake group, single pin 7 or NOR groups |
| sys_clk_en | output | 1 | System clock enable |
| tmr_clk_en | output | 1 | Timer clock enable |
| wake_pulse | output | 1 | One-cycle wake indication |
| rst_req | output | 1 | Post-wake reset request |
| stop_flag | output | 1 | Sticky STOP-recovery flag |

## Verification
A wake edge and a register write can land on the same clock. Both act on the prescaler bit and on the enable cadence that follows. The bench changes the wake pin exactly SYNC_STAGES clocks before it presents a write that sets bit 0 and bit 1, so the write is captured on the wake edge. The result is judged by the per-cycle reference model and by an explicit check that the enables then fire every cycle, which shows the write's bit 1 applied and the wake's bit 0 clear won.

// File: rtl/swc_pkg.sv
package swc_pkg;
   localparam int PA_W = 4;
   localparam int PB_W = 8;
   localparam int PIN_W = PA_W + PB_W;

   typedef enum logic [2:0] {
      SRC_NONE      = 3'd0,
      SRC_PA0       = 3'd1,
      SRC_PA1       = 3'd2,
      SRC_PA2       = 3'd3,
      SRC_PA3       = 3'd4,
      SRC_PB7       = 3'd5,
      SRC_PB_LO_NOR = 3'd6,
      SRC_PB_NOR    = 3'd7
   } wake_src_e;

   // packed MSB first: bit 6 .. bit 0 of the register
   typedef struct packed {
      logic      wake_high;
      logic      short_dly;
      wake_src_e src;
      logic      no_half;
      logic      pre16;
   } ctl_t;
endpackage

// File: rtl/swc_cfg_reg.sv
module swc_cfg_reg
   import swc_pkg::*;
#(
   parameter int         AW   = 8,
   parameter logic [7:0] ADDR = 8'h0B
) (
   input  logic          clk,
   input  logic          por,
   input  logic          ext_rst,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [6:0]    wr_bits,
   input  logic          wake,
   output ctl_t          ctl,
   output logic          flag
);
   localparam logic [AW-1:0] HIT_ADDR = AW'(ADDR);

   generate
      if (AW < 1) begin : g_bad_aw
         $error("swc_cfg_reg: AW must be positive");
      end
   endgenerate

   ctl_t ctl_q;
   logic flag_q;

   always_ff @(posedge clk) begin
      if (por) begin
         ctl_q  <= '0;
         flag_q <= 1'b0;
      end else if (ext_rst) begin
         ctl_q  <= '0;
      end else begin
         if (wr_en && wr_addr == HIT_ADDR)
            ctl_q <= ctl_t'(wr_bits);
         if (wake) begin
            ctl_q.pre16 <= 1'b0;
            flag_q      <= 1'b1;
         end
      end
   end

   assign ctl  = ctl_q;
   assign flag = flag_q;
endmodule

// File: rtl/swc_wake_sel.sv
module swc_wake_sel
   import swc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PA_W-1:0] pa,
   input  logic [PB_W-1:0] pb,
   input  wake_src_e       src,
   input  logic            wake_high,
   output logic            match
);
   logic [PIN_W-1:0] raw, syn;
   logic             lvl;

   assign raw = {pb, pa};

   generate
      if (SYNC_STAGES < 0) begin : g_bad
         $error("swc_wake_sel: SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign syn = raw;
      end else begin : g_sync
         logic [PIN_W-1:0] stg [SYNC_STAGES];
         for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_st
            if (g == 0) begin : g_first
               always_ff @(posedge clk)
                  if (rst) stg[g] <= '0;
                  else     stg[g] <= raw;
            end else begin : g_next
               always_ff @(posedge clk)
                  if (rst) stg[g] <= '0;
                  else     stg[g] <= stg[g-1];
            end
         end
         assign syn = stg[SYNC_STAGES-1];
      end
   endgenerate

   always_comb begin
      case (src)
         SRC_PA0:       lvl = syn[0];
         SRC_PA1:       lvl = syn[1];
         SRC_PA2:       lvl = syn[2];
         SRC_PA3:       lvl = syn[3];
         SRC_PB7:       lvl = syn[PA_W+7];
         SRC_PB_LO_NOR: lvl = ~|syn[PA_W+3:PA_W];
         SRC_PB_NOR:    lvl = ~|syn[PIN_W-1:PA_W];
         default:       lvl = 1'b0;
      endcase
   end

   assign match = (src != SRC_NONE) && (lvl == wake_high);
endmodule

// File: rtl/swc_delay.sv
module swc_delay #(
   parameter int SHORT_DLY = 64,
   parameter int LONG_DLY  = 4096
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic use_short,
   output logic busy
);
   localparam int DW = $clog2(LONG_DLY + 1);

   generate
      if (SHORT_DLY < 1 || LONG_DLY < SHORT_DLY) begin : g_bad
         $error("swc_delay: need 1 <= SHORT_DLY <= LONG_DLY");
      end
   endgenerate

   logic [DW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= use_short ? DW'(SHORT_DLY) : DW'(LONG_DLY);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/swc_clkdiv.sv
module swc_clkdiv #(
   parameter int HALF_DIV = 2,
   parameter int PRE_DIV  = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic hold,
   input  logic no_half,
   input  logic pre16,
   output logic en
);
   localparam int MAXR = HALF_DIV * PRE_DIV;
   localparam int CW   = $clog2(MAXR);

   generate
      if (HALF_DIV < 2 || PRE_DIV < 1) begin : g_bad
         $error("swc_clkdiv: need HALF_DIV >= 2 and PRE_DIV >= 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q, lim;
   int            base;

   assign base = no_half ? 1 : HALF_DIV;

   generate
      if (PRE_DIV > 1) begin : g_pre
         always_comb lim = pre16 ? CW'(base * PRE_DIV - 1) : CW'(base - 1);
      end else begin : g_nopre
         logic unused_pre;
         assign unused_pre = pre16;
         always_comb lim = CW'(base - 1);
      end
   endgenerate

   assign en = !hold && (cnt_q >= lim);

   always_ff @(posedge clk) begin
      if (rst || hold || en) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
   import swc_pkg::*;
#(
   parameter int         AW          = 8,
   parameter logic [7:0] REG_ADDR    = 8'h0B,
   parameter int         SYNC_STAGES = 2,
   parameter int         SHORT_DLY   = 64,
   parameter int         LONG_DLY    = 4096,
   parameter int         HALF_DIV    = 2,
   parameter int         PRE_DIV     = 16
) (
   input  logic          clk,
   input  logic          por,
   input  logic          ext_rst,
   input  logic          stop_req,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   input  logic [3:0]    wake_pa,
   input  logic [7:0]    wake_pb,
   output logic          sys_clk_en,
   output logic          tmr_clk_en,
   output logic          wake_pulse,
   output logic          rst_req,
   output logic          stop_flag
);
   localparam logic [AW-1:0] RD_HIT = AW'(REG_ADDR);

   logic rst_any, in_stop_q, wake_q, match, wake_hit, div_en;
   logic unused_wr7;
   ctl_t ctl;

   assign rst_any    = por | ext_rst;
   assign unused_wr7 = wr_data[7];
   assign wake_hit   = in_stop_q & match;

   swc_cfg_reg #(.AW(AW), .ADDR(REG_ADDR)) u_cfg (
      .clk(clk), .por(por), .ext_rst(ext_rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_bits(wr_data[6:0]), .wake(wake_hit), .ctl(ctl), .flag(stop_flag)
   );

   swc_wake_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
      .clk(clk), .rst(rst_any), .pa(wake_pa), .pb(wake_pb),
      .src(ctl.src), .wake_high(ctl.wake_high), .match(match)
   );

   swc_delay #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_dly (
      .clk(clk), .rst(rst_any), .load(wake_hit), .use_short(ctl.short_dly),
      .busy(rst_req)
   );

   swc_clkdiv #(.HALF_DIV(HALF_DIV), .PRE_DIV(PRE_DIV)) u_div (
      .clk(clk), .rst(rst_any), .hold(in_stop_q), .no_half(ctl.no_half),
      .pre16(ctl.pre16), .en(div_en)
   );

   always_ff @(posedge clk) begin
      if (rst_any) begin
         in_stop_q <= 1'b0;
         wake_q    <= 1'b0;
      end else begin
         wake_q <= wake_hit;
         if (wake_hit)
            in_stop_q <= 1'b0;
         else if (stop_req && !rst_req)
            in_stop_q <= 1'b1;
      end
   end

   assign wake_pulse = wake_q;
   assign sys_clk_en = div_en;
   assign tmr_clk_en = div_en;
   assign rd_data    = (rd_addr == RD_HIT) ? {stop_flag, 7'b0} : 8'h00;
endmodule

// File: rtl/swc_chk.sv
module swc_chk (
   input logic clk,
   input logic por,
   input logic ext_rst,
   input logic stop_req,
   input logic in_stop,
   input logic sys_clk_en,
   input logic tmr_clk_en,
   input logic wake_pulse,
   input logic rst_req,
   input logic stop_flag
);
   p_quiet_in_stop_r3: assert property (@(posedge clk) disable iff (por || ext_rst)
      in_stop |-> (!sys_clk_en && !tmr_clk_en));

   p_enter_stop_r3: assert property (@(posedge clk) disable iff (por || ext_rst)
      (stop_req && !in_stop && !rst_req) |=> in_stop);

   p_single_pulse_r6: assert property (@(posedge clk) disable iff (por || ext_rst)
      wake_pulse |=> !wake_pulse);

   p_wake_from_stop_r6: assert property (@(posedge clk) disable iff (por || ext_rst)
      wake_pulse |-> (!in_stop && $past(in_stop)));

   p_wake_sets_flag_r7: assert property (@(posedge clk) disable iff (por || ext_rst)
      wake_pulse |-> stop_flag);

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (por)
      !$fell(stop_flag));

   p_delay_starts_r8: assert property (@(posedge clk) disable iff (por || ext_rst)
      wake_pulse |-> rst_req);
endmodule

bind stop_wake_ctrl swc_chk u_chk (
   .clk(clk), .por(por), .ext_rst(ext_rst), .stop_req(stop_req),
   .in_stop(in_stop_q), .sys_clk_en(sys_clk_en), .tmr_clk_en(tmr_clk_en),
   .wake_pulse(wake_pulse), .rst_req(rst_req), .stop_flag(stop_flag)
);

// File: tb/sim_stop_wake_ctrl.sv
module sim_stop_wake_ctrl;
   localparam int         CLK_PERIOD = 10;
   localparam int         SYNC  = 2;
   localparam int         SHORT = 64;
   localparam int         LONG  = 4096;
   localparam logic [7:0] ADDR  = 8'h0B;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic       por = 1'b1, ext_rst = 1'b0, stop_req = 1'b0, wr_en = 1'b0;
   logic [7:0] wr_addr = 8'h00, wr_data = 8'h00, rd_addr = 8'h0B, rd_data;
   logic [3:0] wake_pa = 4'h0;
   logic [7:0] wake_pb = 8'h00;
   logic       sys_clk_en, tmr_clk_en, wake_pulse, rst_req, stop_flag;

   stop_wake_ctrl u0 (
      .clk(clk), .por(por), .ext_rst(ext_rst), .stop_req(stop_req),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .wake_pa(wake_pa), .wake_pb(wake_pb),
      .sys_clk_en(sys_clk_en), .tmr_clk_en(tmr_clk_en), .wake_pulse(wake_pulse),
      .rst_req(rst_req), .stop_flag(stop_flag)
   );

   int checks = 0, fails = 0, wake_cnt = 0;
   bit cmp_on = 1'b0, done = 1'b0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [6:0]  m_cfg = '0, cfg_old;
   logic        m_flag = 1'b0, m_stop = 1'b0, m_wake = 1'b0, hit, en_old;
   int          m_dly = 0, m_div = 0, d_old;
   logic [11:0] m_pipe [SYNC];

   function automatic int ratio_of(logic [6:0] c);
      return (c[1] ? 1 : 2) * (c[0] ? 16 : 1);
   endfunction

   function automatic logic level_of(logic [2:0] s, logic [11:0] p);
      case (s)
         3'd1: return p[0];
         3'd2: return p[1];
         3'd3: return p[2];
         3'd4: return p[3];
         3'd5: return p[11];
         3'd6: return ~|p[7:4];
         3'd7: return ~|p[11:4];
         default: return 1'b0;
      endcase
   endfunction

   initial for (int i = 0; i < SYNC; i++) m_pipe[i] = '0;

   always @(posedge clk) begin
      cfg_old = m_cfg;
      d_old   = m_dly;
      en_old  = !m_stop && (m_div >= ratio_of(cfg_old) - 1);
      if (por) m_flag = 1'b0;
      if (por || ext_rst) begin
         m_cfg = '0; m_stop = 1'b0; m_wake = 1'b0; m_dly = 0; m_div = 0;
         for (int i = 0; i < SYNC; i++) m_pipe[i] = '0;
      end else begin
         hit = m_stop && cfg_old[4:2] != 3'd0 &&
               level_of(cfg_old[4:2], m_pipe[SYNC-1]) == cfg_old[6];
         for (int i = SYNC-1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
         m_pipe[0] = {wake_pb, wake_pa};
         m_div = (m_stop || en_old) ? 0 : m_div + 1;
         if (wr_en && wr_addr == ADDR) m_cfg = wr_data[6:0];
         if (m_dly > 0) m_dly--;
         if (hit) begin
            m_cfg[0] = 1'b0;
            m_flag   = 1'b1;
            m_dly    = cfg_old[5] ? SHORT : LONG;
            m_stop   = 1'b0;
         end else if (stop_req && !m_stop && d_old == 0) begin
            m_stop = 1'b1;
         end
         m_wake = hit;
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         logic exp_en;
         exp_en = !m_stop && (m_div >= ratio_of(m_cfg) - 1);
         chk("R9 R10", "sys_clk_en", sys_clk_en, exp_en);
         chk("R9 R10", "tmr_clk_en", tmr_clk_en, exp_en);
         chk("R4 R5 R6", "wake_pulse", wake_pulse, m_wake);
         chk("R8", "rst_req", rst_req, m_dly != 0);
         chk("R7", "stop_flag", stop_flag, m_flag);
         chk("R2", "rd_data", rd_data, (rd_addr == ADDR) ? {m_flag, 7'b0} : 8'h00);
         if (wake_pulse) wake_cnt++;
      end
   end

   // ---------------- stimulus ----------------
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic run(int n);
      repeat (n) tick();
   endtask

   task automatic wr(logic [7:0] d);
      wr_en = 1'b1; wr_addr = ADDR; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic req_stop();
      stop_req = 1'b1;
      tick();
      stop_req = 1'b0;
   endtask

   task automatic set_pins(logic [11:0] p);
      {wake_pb, wake_pa} = p;
   endtask

   function automatic logic [11:0] pins_for(int s, logic lvl);
      case (s)
         6:       return lvl ? 12'h000 : 12'h010;
         7:       return lvl ? 12'h000 : 12'h800;
         default: return {12{lvl}};
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      report();
   end

   initial begin
      tick();
      cmp_on = 1'b1;
      run(2);
      por = 1'b0;
      @(negedge clk);
      chk("R1", "flag after por", stop_flag, 1'b0);
      chk("R1", "rst_req after por", rst_req, 1'b0);
      chk("R1", "wake after por", wake_pulse, 1'b0);
      chk("R1", "rd_data after por", rd_data, 8'h00);
      tick();

      // divide ratios
      run(20);
      wr(8'h02); run(10);
      wr(8'h03); run(40);
      wr(8'h01); run(70);
      wr(8'h80); run(2);
      @(negedge clk);
      chk("R2", "bit7 write ignored", rd_data, 8'h00);
      tick();
      rd_addr = 8'h0C; run(3); rd_addr = ADDR;

      // every wake source, both levels
      for (int s = 1; s <= 7; s++) begin
         logic pol;
         pol = s[0];
         set_pins(pins_for(s, !pol));
         run(4);
         wr({1'b0, pol, 1'b1, 3'(s), 2'b11});
         req_stop();
         run(10);
         @(negedge clk);
         chk("R3", "enable silent in stop", sys_clk_en, 1'b0);
         tick();
         set_pins(pins_for(s, pol));
         run(SHORT + 12);
      end
      @(negedge clk);
      chk("R4", "wakes over seven sources", wake_cnt, 7);
      tick();

      // source none: pins cannot wake, external reset exits STOP
      wr(8'h20);
      req_stop();
      for (int k = 0; k < 30; k++) begin
         set_pins(12'(k * 12'h35B));
         tick();
      end
      @(negedge clk);
      chk("R4", "no wake with source 000", wake_cnt, 7);
      chk("R3", "still quiet in stop", sys_clk_en, 1'b0);
      tick();
      ext_rst = 1'b1; tick(); ext_rst = 1'b0;
      run(3);
      @(negedge clk);
      chk("R11", "ext reset leaves stop", sys_clk_en | tmr_clk_en | (m_div == 1), 1'b1);
      chk("R7", "flag kept over ext reset", stop_flag, 1'b1);
      tick();
      run(20);

      // long delay; stop request during it is ignored
      set_pins(12'h000); run(4);
      wr(8'h46);
      req_stop();
      run(4);
      set_pins(12'hFFF);
      run(10);
      req_stop();
      run(LONG + 20);
      set_pins(12'h000);
      run(4);

      // wake and write captured on the same edge
      wr(8'h65);
      req_stop();
      run(5);
      set_pins(12'hFFF);
      tick(); tick();
      wr(8'h67);
      run(SHORT + 4);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R10", "wake clears prescale over write", sys_clk_en, 1'b1);
      end
      tick();
      set_pins(12'h000);
      run(6);

      // power-on clears the flag
      por = 1'b1; run(2); por = 1'b0; tick();
      @(negedge clk);
      chk("R7", "flag cleared by por", stop_flag, 1'b0);
      tick();
      run(5);
      report();
   end
endmodule